// File: doc/BRIEF.md
# Converter Output-Rate and Settling Sequencer

This block is the digital timing core of a sigma-delta converter front end. It holds an 8-bit clock configuration register, turns the master clock into an internal count rate (either the master clock itself or the master clock halved), and drives a gated copy of the master clock to a pin for use elsewhere on the board. From the internal rate it counts out the output update period chosen by a 3-bit rate code, and raises a one-cycle data-ready strobe at the end of each period.

The block also tracks digital-filter settling. After reset, or after a write that changes the rate code, four full update periods must pass before output is trusted. While a filter-sync input is held high the period count is frozen at zero. When that input drops, only three periods are needed. A settled flag shows when data-ready strobes are being issued.

The internal clock is a clock enable on the master clock rather than a second clock domain. The period for each rate code comes from internal-clock frequencies given as parameters and is rounded to the nearest whole cycle.

Top module: `rate_seq_top`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x05, `settled` is 0 and `cfg_err` is 0.
- R2: The register fields are: bits 7:5 reserved, bit 4 clock-output disable, bit 3 divide-by-2, bit 2 clock-range select, bits 1:0 filter select. All 8 bits read back as written. Writing any 1 into bits 7:5 sets `cfg_err`, which stays set until reset.
- R3: The rate code {bit2,bit1,bit0} picks the update period in internal cycles, rounded from HI_HZ or LO_HZ divided by the rate. The rates are 0→20, 1→25, 2→100, 3→200 (all on LO_HZ) and 4→50, 5→60, 6→250, 7→500 (all on HI_HZ).
- R4: With bit 3 set, one internal cycle is two master-clock cycles, so every period doubles in master cycles.
- R5: With bit 4 set, `mclk_out` is held low. With bit 4 clear, it follows `mclk`. Period counting and strobes continue in both cases.
- R6: After reset, or a write that changes bits 2:0, the first strobe comes exactly 4 periods after the clock edge that took the reset or the write. `settled` rises with that strobe, and no strobe appears before it.
- R7: While `fsync` is high there is no strobe and `settled` is 0. The first strobe comes 3 periods after the last edge at which `fsync` was sampled high.
- R8: While settled, `drdy` is high for exactly one cycle once per period.
- R9: A write that leaves bits 2:0 unchanged does not restart the period count and does not clear `settled`.
- R10: A rate-changing write taken on the edge where a strobe would have been issued wins: no strobe appears, and settling restarts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| fsync | input | 1 | Filter sync; high holds the filter in reset |
| mclk_out | output | 1 | Gated master clock output |
| drdy | output | 1 | One-cycle data-ready strobe |
| settled | output | 1 | Filter settled flag |
| cfg_err | output | 1 | Sticky flag for a nonzero write to reserved bits |

## Verification
A rate-code write and a period-end strobe can fall on the same master-clock edge. The bench first measures the strobe cadence of a settled stream. It then times a write of a new rate code so that the write lands exactly on the edge that would carry the next strobe. It passes if `drdy` stays low on that edge, `settled` drops, and the next strobe arrives four new periods after the write. A write that keeps the rate code, placed mid-period, is also checked to leave the cadence untouched.

// File: rtl/rate_seq_pkg.sv
`timescale 1ns/1ps
package rate_seq_pkg;

  typedef struct packed {
    logic [2:0] rsvd;
    logic       clk_off;
    logic       half_rate;
    logic [2:0] code;
  } cfg_t;

  localparam logic [7:0] CFG_RESET = 8'h05;

  function automatic int unsigned code_hz(input int unsigned code);
    case (code)
      0: code_hz = 20;
      1: code_hz = 25;
      2: code_hz = 100;
      3: code_hz = 200;
      4: code_hz = 50;
      5: code_hz = 60;
      6: code_hz = 250;
      default: code_hz = 500;
    endcase
  endfunction

  function automatic int unsigned code_period(input int unsigned code,
                                              input int unsigned hi_hz,
                                              input int unsigned lo_hz);
    int unsigned f;
    int unsigned r;
    f = (code >= 4) ? hi_hz : lo_hz;
    r = code_hz(code);
    code_period = (f + r / 2) / r;
  endfunction

  function automatic int unsigned max_period(input int unsigned hi_hz,
                                             input int unsigned lo_hz);
    int unsigned m;
    m = 1;
    for (int unsigned c = 0; c < 8; c++)
      if (code_period(c, hi_hz, lo_hz) > m) m = code_period(c, hi_hz, lo_hz);
    max_period = m;
  endfunction

endpackage

// File: rtl/clk_tick.sv
`timescale 1ns/1ps
module clk_tick (
  input  logic clk,
  input  logic rst,
  input  logic half_rate,
  input  logic phase_clr,
  input  logic out_off,
  output logic tick,
  output logic clk_out
);
  logic phase_q;
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst || phase_clr) phase_q <= 1'b0;
    else                  phase_q <= ~phase_q;
  end

  assign tick = ~half_rate | phase_q;

  // enable changes only while clk is low, so the gated output never chops a pulse
  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b1;
    else     gate_q <= ~out_off;
  end

  assign clk_out = clk & gate_q;
endmodule

// File: rtl/rate_timer.sv
`timescale 1ns/1ps
module rate_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic          hold,
  input  logic [CW-1:0] period,
  output logic          drdy,
  output logic          settled
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic [1:0]    nwrap_q;
  logic          short_q;
  logic [1:0]    last_wrap;
  logic          at_end;

  assign last_wrap = short_q ? 2'd2 : 2'd3;
  assign at_end    = (cnt_q == period - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      nwrap_q <= '0;
      short_q <= 1'b0;
      settled <= 1'b0;
      drdy    <= 1'b0;
    end else begin
      drdy <= 1'b0;
      if (restart) begin
        cnt_q   <= '0;
        nwrap_q <= '0;
        short_q <= 1'b0;
        settled <= 1'b0;
      end else if (hold) begin
        cnt_q   <= '0;
        nwrap_q <= '0;
        short_q <= 1'b1;
        settled <= 1'b0;
      end else if (tick) begin
        if (at_end) begin
          cnt_q <= '0;
          if (settled) begin
            drdy <= 1'b1;
          end else if (nwrap_q == last_wrap) begin
            settled <= 1'b1;
            drdy    <= 1'b1;
          end else begin
            nwrap_q <= nwrap_q + 2'd1;
          end
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end
    end
  end

  // R8
  drdy_single_chk: assert property (@(posedge clk) disable iff (rst)
    drdy |=> !drdy);

  // R6
  drdy_needs_settle_chk: assert property (@(posedge clk) disable iff (rst)
    drdy |-> settled);

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!drdy && !settled));
endmodule

// File: rtl/rate_seq_top.sv
`timescale 1ns/1ps
module rate_seq_top
  import rate_seq_pkg::*;
#(
  parameter int unsigned HI_HZ = 2457600,
  parameter int unsigned LO_HZ = 1000000
) (
  input  logic       mclk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       fsync,
  output logic       mclk_out,
  output logic       drdy,
  output logic       settled,
  output logic       cfg_err
);
  localparam int unsigned PMAX = max_period(HI_HZ, LO_HZ);
  localparam int unsigned CW   = $clog2(PMAX + 1);

  cfg_t          cfg_q;
  cfg_t          wr_cfg;
  logic          restart;
  logic          tick;
  logic [CW-1:0] per_tbl [8];

  assign wr_cfg  = cfg_t'(wr_data);
  assign restart = wr_en && (wr_cfg.code != cfg_q.code);

  always_ff @(posedge mclk) begin
    if (rst) begin
      cfg_q   <= cfg_t'(CFG_RESET);
      cfg_err <= 1'b0;
    end else if (wr_en) begin
      cfg_q <= wr_cfg;
      if (wr_cfg.rsvd != 3'b000) cfg_err <= 1'b1;
    end
  end

  assign rd_data = cfg_q;

  for (genvar g = 0; g < 8; g++) begin : g_rate
    localparam int unsigned PV = code_period(g, HI_HZ, LO_HZ);
    assign per_tbl[g] = CW'(PV);
  end

  clk_tick u_tick (
    .clk       (mclk),
    .rst       (rst),
    .half_rate (cfg_q.half_rate),
    .phase_clr (restart | fsync),
    .out_off   (cfg_q.clk_off),
    .tick      (tick),
    .clk_out   (mclk_out)
  );

  rate_timer #(.CW(CW)) u_timer (
    .clk     (mclk),
    .rst     (rst),
    .tick    (tick),
    .restart (restart),
    .hold    (fsync),
    .period  (per_tbl[cfg_q.code]),
    .drdy    (drdy),
    .settled (settled)
  );

  // R1
  reset_value_chk: assert property (@(posedge mclk)
    rst |=> (rd_data == 8'h05 && !cfg_err && !settled));

  // R2
  rsvd_err_chk: assert property (@(posedge mclk) disable iff (rst)
    (wr_en && wr_data[7:5] != 3'b000) |=> cfg_err);

  // R6
  restart_clear_chk: assert property (@(posedge mclk) disable iff (rst)
    (wr_en && wr_data[2:0] != rd_data[2:0]) |=> (!settled && !drdy));

  // R2
  err_sticky_chk: assert property (@(posedge mclk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

// File: tb/rate_seq_top_test.sv
`timescale 1ns/1ps
module rate_seq_top_test;
  logic       mclk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       fsync = 1'b0;
  logic [7:0] rd_data;
  logic       mclk_out, drdy, settled, cfg_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // periods for HI_HZ=2500, LO_HZ=1000, indexed by rate code
  int exp_per [8] = '{50, 40, 10, 5, 50, 42, 10, 5};

  always #2 mclk = ~mclk;

  rate_seq_top #(.HI_HZ(2500), .LO_HZ(1000)) uut (
    .mclk(mclk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .fsync(fsync), .mclk_out(mclk_out),
    .drdy(drdy), .settled(settled), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge mclk);
    wr_en = 1'b1;
    wr_data = v;
    @(posedge mclk);
    #1;
    wr_en = 1'b0;
  endtask

  // edges counted from the last edge already passed until drdy is seen high
  task automatic wait_drdy(input int maxc, output int n);
    n = 0;
    do begin
      @(posedge mclk);
      #1;
      n++;
    end while (!drdy && n < maxc);
    if (!drdy) n = -1;
  endtask

  task automatic t_reset;
    int n;
    rst = 1'b1;
    repeat (3) @(posedge mclk);
    #1;
    check(settled == 1'b0, "R1 settled in reset", settled, 0);
    @(negedge mclk);
    rst = 1'b0;
    #1;
    check(rd_data == 8'h05, "R1 reset value", rd_data, 5);
    check(cfg_err == 1'b0, "R1 err after reset", cfg_err, 0);
    @(posedge mclk);
    #1;
    check(mclk_out == 1'b1, "R5 clock out high phase", mclk_out, 1);
    @(negedge mclk);
    #1;
    check(mclk_out == 1'b0, "R5 clock out low phase", mclk_out, 0);
    wait_drdy(1000, n);
    n = n + 1;  // first edge was skipped by the negedge sample above
    check(n == 4 * exp_per[5], "R6 first strobe after reset", n, 4 * exp_per[5]);
    check(settled == 1'b1, "R6 settled with first strobe", settled, 1);
    @(posedge mclk);
    #1;
    check(drdy == 1'b0, "R8 strobe width", drdy, 0);
    wait_drdy(1000, n);
    n = n + 1;
    check(n == exp_per[5], "R8 period code 5", n, exp_per[5]);
  endtask

  task automatic t_rate(input int code);
    int n;
    write_reg(8'(code));
    check(settled == 1'b0, "R6 settled cleared by rate write", settled, 0);
    check(rd_data == 8'(code), "R2 readback", rd_data, code);
    wait_drdy(2000, n);
    check(n == 4 * exp_per[code], "R3 R6 settle length", n, 4 * exp_per[code]);
    wait_drdy(2000, n);
    check(n == exp_per[code], "R3 period", n, exp_per[code]);
  endtask

  task automatic t_div;
    int n;
    write_reg(8'h0F);
    wait_drdy(2000, n);
    check(n == 8 * exp_per[7], "R4 halved settle", n, 8 * exp_per[7]);
    wait_drdy(2000, n);
    check(n == 2 * exp_per[7], "R4 halved period", n, 2 * exp_per[7]);
  endtask

  task automatic t_sync;
    int n;
    int seen;
    write_reg(8'h06);
    wait_drdy(2000, n);
    @(negedge mclk);
    fsync = 1'b1;
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge mclk);
      #1;
      if (drdy || settled) seen++;
    end
    check(seen == 0, "R7 quiet while sync high", seen, 0);
    @(negedge mclk);
    fsync = 1'b0;
    wait_drdy(2000, n);
    check(n == 3 * exp_per[6], "R7 settle after sync", n, 3 * exp_per[6]);
    check(settled == 1'b1, "R7 settled after sync", settled, 1);
  endtask

  task automatic t_same_code;
    int n;
    int hi_cnt;
    wait_drdy(2000, n);
    repeat (3) @(posedge mclk);
    write_reg(8'h96);  // same code, output off, reserved bit 7 set
    check(rd_data == 8'h96, "R2 reserved readback", rd_data, 8'h96);
    check(cfg_err == 1'b1, "R2 reserved error", cfg_err, 1);
    check(settled == 1'b1, "R9 settled kept", settled, 1);
    wait_drdy(2000, n);
    check(n == exp_per[6] - 4, "R9 cadence kept", n, exp_per[6] - 4);
    hi_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge mclk);
      #1;
      if (mclk_out) hi_cnt++;
    end
    check(hi_cnt == 0, "R5 clock out held low", hi_cnt, 0);
    wait_drdy(2000, n);
    check(n == exp_per[6] - 8, "R5 timing continues", n, exp_per[6] - 8);
  endtask

  task automatic t_collide;
    int n;
    write_reg(8'h06);
    check(cfg_err == 1'b1, "R2 error sticky", cfg_err, 1);
    @(posedge mclk);
    #1;
    check(mclk_out == 1'b1, "R5 clock out re-enabled", mclk_out, 1);
    wait_drdy(2000, n);
    repeat (exp_per[6] - 1) @(posedge mclk);
    write_reg(8'h02);
    check(drdy == 1'b0, "R10 strobe dropped on write edge", drdy, 0);
    check(settled == 1'b0, "R10 settled cleared", settled, 0);
    wait_drdy(2000, n);
    check(n == 4 * exp_per[2], "R10 restart from write", n, 4 * exp_per[2]);
  endtask

  initial begin
    t_reset();
    t_rate(3);
    t_rate(1);
    t_rate(6);
    t_div();
    t_sync();
    t_same_code();
    t_collide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule